// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical memory address by picking one of four 16-bit segment registers, multiplying it by sixteen and adding the offset. Which segment is used follows from the kind of access being made: instruction fetch, stack access, general data access or string destination. A segment prefix presented together with the access replaces that default choice for one cycle.

The four segment registers (code, data, stack, extra) share one write-data bus and each has its own load strobe. A load that coincides with an access that uses the same register is forwarded, so the access sees the freshly written value. The computed address is registered: it appears on the output one clock after the inputs that produced it. Reset puts the code segment at FFFFh and the output at the reset fetch address FFFF0h.

The block has no sequencing state. Its only timing rules are the one-cycle output register and the write-through of segment loads.

Top module: `seg_addr_gen`

## Requirements
- R1: One clock after an access is presented, `phys_addr` equals (segment × 16 + `offset`), where the segment is the register chosen for that access.
- R2: With `pfx_valid` low, `acc_kind` = 00 (instruction fetch) uses the code segment.
- R3: With `pfx_valid` low, `acc_kind` = 01 (stack access) uses the stack segment.
- R4: With `pfx_valid` low, `acc_kind` = 10 (general data) uses the data segment.
- R5: With `pfx_valid` low, `acc_kind` = 11 (string destination) uses the extra segment.
- R6: With `pfx_valid` high, `pfx_sel` picks the segment whatever `acc_kind` is: 00 extra, 01 code, 10 stack, 11 data.
- R7: With `pfx_valid` low, the value of `pfx_sel` has no effect on `phys_addr`.
- R8: Reset sets the code segment to FFFFh, the data, stack and extra segments to 0000h, and `phys_addr` to FFFF0h. A fetch at offset 0000h after reset yields FFFF0h.
- R9: A high load strobe writes `seg_wdata` into its segment register at the clock edge. A segment register whose strobe is low keeps its value.
- R10: When a segment is loaded in the same cycle as an access that uses it, the access uses the new value.
- R11: Any carry out of bit 19 of the sum is dropped, so addresses wrap within 1 MB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_load | input | 1 | Load strobe for the code segment |
| ds_load | input | 1 | Load strobe for the data segment |
| ss_load | input | 1 | Load strobe for the stack segment |
| es_load | input | 1 | Load strobe for the extra segment |
| seg_wdata | input | 16 | Value written by any active load strobe |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 stack, 10 data, 11 string destination |
| pfx_valid | input | 1 | Segment prefix present |
| pfx_sel | input | 2 | Prefix segment: 00 extra, 01 code, 10 stack, 11 data |
| offset | input | 16 | Offset within the segment |
| phys_addr | output | 20 | Registered physical address |

## Verification
A segment load and an address computation can happen in the same cycle, and both can involve the same register. The bench provokes this by presenting a load strobe together with an access whose default or prefix segment is that register. This is done once for each of the four registers, and once with all four strobes high together. The address that appears one clock later must be built from the new write data, while later accesses must show that the register kept that value.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    // Segment index; the encoding matches the prefix selector.
    typedef enum logic [1:0] {
        SEG_EXTRA = 2'b00,
        SEG_CODE  = 2'b01,
        SEG_STACK = 2'b10,
        SEG_DATA  = 2'b11
    } seg_id_e;

    // Kind of memory access requesting an address.
    typedef enum logic [1:0] {
        ACC_FETCH  = 2'b00,
        ACC_STACK  = 2'b01,
        ACC_DATA   = 2'b10,
        ACC_STRDST = 2'b11
    } acc_kind_e;

    localparam int unsigned SEG_COUNT = 4;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int unsigned  SEG_W  = 16,
    parameter logic [15:0]  CS_RST = 16'hFFFF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [SEG_COUNT-1:0]              load_mask,
    input  logic [SEG_W-1:0]                  wdata,
    output logic [SEG_COUNT-1:0][SEG_W-1:0]   seg_q,
    output logic [SEG_COUNT-1:0][SEG_W-1:0]   seg_fwd
);

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
        // Only the code segment has a non-zero reset value.
        localparam logic [SEG_W-1:0] RST_VAL =
            (g == int'(SEG_CODE)) ? SEG_W'(CS_RST) : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_q[g] <= RST_VAL;
            end else if (load_mask[g]) begin
                seg_q[g] <= wdata;
            end
        end

        // Write-through view used by a same-cycle access.
        always_comb begin
            seg_fwd[g] = load_mask[g] ? wdata : seg_q[g];
        end

        // R9: an unloaded register keeps its value
        p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !load_mask[g] |=> $stable(seg_q[g]));

        // R9: a loaded register takes the write data
        p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
            load_mask[g] |=> seg_q[g] == $past(wdata));
    end

endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  acc_kind_e  kind,
    input  logic       pfx_valid,
    input  seg_id_e    pfx_sel,
    output seg_id_e    sel
);

    seg_id_e dflt;

    always_comb begin
        unique case (kind)
            ACC_FETCH:  dflt = SEG_CODE;
            ACC_STACK:  dflt = SEG_STACK;
            ACC_DATA:   dflt = SEG_DATA;
            ACC_STRDST: dflt = SEG_EXTRA;
            default:    dflt = SEG_DATA;
        endcase
    end

    always_comb begin
        sel = pfx_valid ? pfx_sel : dflt;
    end

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned SHIFT = 4,
    localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] seg_sh;
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        seg_sh  = {seg, {SHIFT{1'b0}}};
        off_ext = ADDR_W'(off);
        // The sum is kept at ADDR_W bits; the top carry falls away.
        addr    = seg_sh + off_ext;
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned SHIFT  = 4,
    parameter logic [15:0] CS_RST = 16'hFFFF,
    localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_load,
    input  logic              ds_load,
    input  logic              ss_load,
    input  logic              es_load,
    input  logic [SEG_W-1:0]  seg_wdata,
    input  logic [1:0]        acc_kind,
    input  logic              pfx_valid,
    input  logic [1:0]        pfx_sel,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] phys_addr
);

    localparam logic [ADDR_W-1:0] RST_ADDR = {SEG_W'(CS_RST), {SHIFT{1'b0}}};

    logic [SEG_COUNT-1:0]            load_mask;
    logic [SEG_COUNT-1:0][SEG_W-1:0] seg_q;
    logic [SEG_COUNT-1:0][SEG_W-1:0] seg_fwd;
    seg_id_e                         sel;
    logic [SEG_W-1:0]                seg_val;
    logic [ADDR_W-1:0]               addr_d;

    always_comb begin
        load_mask                 = '0;
        load_mask[int'(SEG_EXTRA)] = es_load;
        load_mask[int'(SEG_CODE)]  = cs_load;
        load_mask[int'(SEG_STACK)] = ss_load;
        load_mask[int'(SEG_DATA)]  = ds_load;
    end

    seg_regfile #(
        .SEG_W  (SEG_W),
        .CS_RST (CS_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_mask (load_mask),
        .wdata     (seg_wdata),
        .seg_q     (seg_q),
        .seg_fwd   (seg_fwd)
    );

    seg_select u_sel (
        .kind      (acc_kind_e'(acc_kind)),
        .pfx_valid (pfx_valid),
        .pfx_sel   (seg_id_e'(pfx_sel)),
        .sel       (sel)
    );

    always_comb begin
        seg_val = seg_fwd[sel];
    end

    seg_adder #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT)
    ) u_add (
        .seg  (seg_val),
        .off  (offset),
        .addr (addr_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phys_addr <= RST_ADDR;
        end else begin
            phys_addr <= addr_d;
        end
    end

    // Reference arithmetic for the checks: multiply, add, reduce modulo 2^ADDR_W.
    function automatic logic [ADDR_W-1:0] ref_addr(input logic [SEG_W-1:0] s,
                                                   input logic [OFF_W-1:0] o);
        longint unsigned full;
        full = longint'(s) * (longint'(1) << SHIFT) + longint'(o);
        return ADDR_W'(full % (longint'(1) << ADDR_W));
    endfunction

    // R2: a plain fetch uses the code segment (R1, R11 arithmetic)
    p_fetch_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'b00 && !pfx_valid && load_mask == '0)
        |=> phys_addr == ref_addr($past(seg_q[1]), $past(offset)));

    // R3: a plain stack access uses the stack segment
    p_stack_ss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'b01 && !pfx_valid && load_mask == '0)
        |=> phys_addr == ref_addr($past(seg_q[2]), $past(offset)));

    // R4: a plain data access uses the data segment
    p_data_ds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'b10 && !pfx_valid && load_mask == '0)
        |=> phys_addr == ref_addr($past(seg_q[3]), $past(offset)));

    // R5: a string destination uses the extra segment
    p_strdst_es_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'b11 && !pfx_valid && load_mask == '0)
        |=> phys_addr == ref_addr($past(seg_q[0]), $past(offset)));

    // R6: a valid prefix selects the segment
    p_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_valid && load_mask == '0)
        |=> phys_addr == ref_addr($past(seg_q[pfx_sel]), $past(offset)));

    // R10: a code segment load in the same cycle as a fetch is seen by it
    p_forward_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_load && acc_kind == 2'b00 && !pfx_valid)
        |=> phys_addr == ref_addr($past(seg_wdata), $past(offset)));

endmodule

// File: tb/seg_addr_gen_test.sv
`timescale 1ns/1ps
module seg_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_load = 1'b0, ds_load = 1'b0, ss_load = 1'b0, es_load = 1'b0;
    logic [15:0] seg_wdata = '0;
    logic [1:0]  acc_kind = 2'b00;
    logic        pfx_valid = 1'b0;
    logic [1:0]  pfx_sel = 2'b00;
    logic [15:0] offset = '0;
    logic [19:0] phys_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    seg_addr_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_load   (cs_load),
        .ds_load   (ds_load),
        .ss_load   (ss_load),
        .es_load   (es_load),
        .seg_wdata (seg_wdata),
        .acc_kind  (acc_kind),
        .pfx_valid (pfx_valid),
        .pfx_sel   (pfx_sel),
        .offset    (offset),
        .phys_addr (phys_addr)
    );

    // Model segments, index 0 extra, 1 code, 2 stack, 3 data.
    logic [15:0] m_seg [4];

    // Vector: {ld cs,ds,ss,es}[40:37] wdata[36:21] kind[20:19] pv[18] ps[17:16] off[15:0]
    localparam int NV = 13;
    localparam logic [40:0] VEC [NV] = '{
        {4'b0000, 16'h0000, 2'b00, 1'b0, 2'b00, 16'h0000}, // R8 R2 reset fetch
        {4'b0100, 16'h1234, 2'b10, 1'b0, 2'b00, 16'h0010}, // R10 R4 load DS + data
        {4'b0010, 16'h2000, 2'b01, 1'b0, 2'b00, 16'hFFFE}, // R10 R3 load SS + stack
        {4'b0001, 16'hABCD, 2'b11, 1'b0, 2'b00, 16'h0001}, // R10 R5 load ES + strdst
        {4'b1000, 16'hF000, 2'b00, 1'b0, 2'b00, 16'h1234}, // R10 R2 load CS + fetch
        {4'b0000, 16'h0000, 2'b10, 1'b1, 2'b00, 16'h0000}, // R6 prefix extra
        {4'b0000, 16'h0000, 2'b10, 1'b1, 2'b01, 16'h0042}, // R6 prefix code
        {4'b0000, 16'h0000, 2'b11, 1'b1, 2'b10, 16'h0100}, // R6 prefix stack
        {4'b0000, 16'h0000, 2'b00, 1'b1, 2'b11, 16'h0003}, // R6 prefix data
        {4'b0000, 16'h0000, 2'b01, 1'b0, 2'b00, 16'h0007}, // R7 sel ignored
        {4'b1000, 16'hFFFF, 2'b00, 1'b0, 2'b11, 16'hFFFF}, // R11 wrap
        {4'b0000, 16'h5555, 2'b10, 1'b0, 2'b00, 16'h0000}, // R9 DS held
        {4'b1111, 16'h0100, 2'b01, 1'b1, 2'b11, 16'h0009}  // R10 all loads + prefix
    };
    localparam int VREQ [NV] = '{8, 10, 10, 10, 10, 6, 6, 6, 6, 7, 11, 9, 10};

    task automatic check(input int req, input logic [19:0] act, input logic [19:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: phys_addr=%05h expected=%05h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] model_addr(input logic [40:0] v);
        logic [3:0]  ld;
        logic [15:0] eff [4];
        int          idx;
        ld = v[40:37];
        eff[1] = ld[3] ? v[36:21] : m_seg[1];
        eff[3] = ld[2] ? v[36:21] : m_seg[3];
        eff[2] = ld[1] ? v[36:21] : m_seg[2];
        eff[0] = ld[0] ? v[36:21] : m_seg[0];
        if (v[18]) idx = int'(v[17:16]);
        else case (v[20:19])
            2'b00: idx = 1;
            2'b01: idx = 2;
            2'b10: idx = 3;
            default: idx = 0;
        endcase
        return 20'((32'(eff[idx]) * 16 + 32'(v[15:0])) % 32'h100000);
    endfunction

    task automatic model_reset();
        m_seg[0] = 16'h0000; m_seg[1] = 16'hFFFF;
        m_seg[2] = 16'h0000; m_seg[3] = 16'h0000;
    endtask

    task automatic drive(input logic [40:0] v);
        cs_load = v[40]; ds_load = v[39]; ss_load = v[38]; es_load = v[37];
        seg_wdata = v[36:21]; acc_kind = v[20:19];
        pfx_valid = v[18]; pfx_sel = v[17:16]; offset = v[15:0];
    endtask

    task automatic model_load(input logic [40:0] v);
        if (v[40]) m_seg[1] = v[36:21];
        if (v[39]) m_seg[3] = v[36:21];
        if (v[38]) m_seg[2] = v[36:21];
        if (v[37]) m_seg[0] = v[36:21];
    endtask

    initial begin
        logic [19:0] exp;
        model_reset();
        repeat (3) @(negedge clk);
        check(8, phys_addr, 20'hFFFF0);            // R8 during reset
        rst_n = 1'b1;
        check(8, phys_addr, 20'hFFFF0);            // R8 just after release

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            exp = model_addr(VEC[i]);
            @(negedge clk);
            check(VREQ[i], phys_addr, exp);
            model_load(VEC[i]);
        end

        // R7: same access with the other prefix selector gives the same address
        drive({4'b0000, 16'h0, 2'b01, 1'b0, 2'b10, 16'h0007});
        @(negedge clk);
        check(7, phys_addr, 20'h01007);

        // R8: reset in mid-run restores every segment
        drive('0);
        rst_n = 1'b0;
        @(negedge clk);
        check(8, phys_addr, 20'hFFFF0);
        rst_n = 1'b1;
        model_reset();
        drive({4'b0000, 16'h0, 2'b10, 1'b0, 2'b00, 16'h0005});
        @(negedge clk);
        check(8, phys_addr, 20'h00005);            // R8 data segment back to zero
        drive({4'b0000, 16'h0, 2'b00, 1'b0, 2'b00, 16'h0000});
        @(negedge clk);
        check(8, phys_addr, 20'hFFFF0);            // R8 code segment back to FFFFh
        drive({4'b0000, 16'h0, 2'b00, 1'b0, 2'b00, 16'h0011});
        @(negedge clk);
        check(11, phys_addr, 20'h00001);           // R11 FFFF0h + 11h wraps
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 20000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule